// File: doc/BRIEF.md
# Adaptive Non-Overlap Gate Controller

This block turns a PWM duty command into the two gate enables of a synchronous buck power stage. It compares the duty command with a free-running period count from a fixed-frequency oscillator (about 300 kHz) to form a PWM request. The high-side gate is on while the request is high, and the low-side gate is on while it is low. Duty can span the whole range. A command of 0 keeps the low-side gate on for the whole period. A command at or above the period length keeps the high-side gate on for the whole period. In both cases no dead-time cycle is inserted.

Dead time is adaptive. Before one gate is enabled, the controller turns both gates off and waits until a status input reports that the opposite gate is below its off threshold. A wait counter bounds this interval, so the total dead time stays under 100 ns. When the bound is reached without feedback, the transition goes ahead and a sticky warning flag is raised. Driving the enable input low forces both gates off.

States:
- `ST_OFF`: both gates off, block disabled.
- `ST_LS_ON`: low-side gate on.
- `ST_WAIT_HS`: both gates off, waiting for the low side to read off before the high side turns on.
- `ST_HS_ON`: high-side gate on.
- `ST_WAIT_LS`: both gates off, waiting for the high side to read off before the low side turns on.

Transitions:
- `ST_OFF`→`ST_WAIT_HS` or `ST_WAIT_LS` on enable, chosen by the request.
- `ST_LS_ON`→`ST_WAIT_HS` when the request rises.
- `ST_WAIT_HS`→`ST_HS_ON` when the low side reads off, or when the wait bound expires.
- `ST_HS_ON`→`ST_WAIT_LS` when the request falls.
- `ST_WAIT_LS`→`ST_LS_ON` when the high side reads off, or when the wait bound expires.
- Any state→`ST_OFF` when enable is low.

Top module: `gate_nonoverlap_ctrl`

## Requirements
- R1: While rst_n is low, hs_gate, ls_gate and dt_warn are all 0. After reset the controller is in `ST_OFF`.
- R2: The PWM request is 1 exactly when duty_cmd is greater than phase_cnt. Once settled, hs_gate follows a request of 1 and ls_gate follows a request of 0.
- R3: hs_gate rises only in the cycle after a clock edge at which the controller was in `ST_WAIT_HS` and either ls_off was 1 or the wait bound expired.
- R4: ls_gate rises only in the cycle after a clock edge at which the controller was in `ST_WAIT_LS` and either hs_off was 1 or the wait bound expired.
- R5: A wait state lasts at most DT_MAX cycles. If the awaited off status has not arrived by then, the pending gate turns on anyway and dt_warn becomes 1 in that same cycle.
- R6: Once set, dt_warn stays 1 until reset.
- R7: One cycle after enable is sampled low, both hs_gate and ls_gate are 0, whatever the state was.
- R8: With duty_cmd equal to 0, ls_gate stays 1 for the whole period. With duty_cmd at or above PERIOD, hs_gate stays 1 for the whole period. Neither case has a dead-time gap inside the period.
- R9: hs_gate and ls_gate are never both 1 in the same cycle.
- R10: When enable rises from `ST_OFF`, the first gate to turn on passes through its wait state, so it is on no earlier than two cycles after enable is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | 1 runs the controller; 0 forces both gates off |
| phase_cnt | input | CNT_W | Period count, 0 to PERIOD-1 |
| duty_cmd | input | CNT_W | On-time of the high side in counts; 0 means 0 %, PERIOD or more means 100 % |
| hs_off | input | 1 | 1 when the high-side gate is sensed below its off threshold |
| ls_off | input | 1 | 1 when the low-side gate is sensed below its off threshold |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |
| dt_warn | output | 1 | Sticky flag: a dead-time wait ended on the bound, not on feedback |

## Verification
Timing is the same for every output:
- The request is combinational, and the state register is the only stage before the gate outputs. Any input sampled at an edge therefore shows on hs_gate, ls_gate and dt_warn right after that edge.
- A gate turns on one cycle after the edge at which its off feedback is seen.
- Disable acts one cycle after enable is sampled low.

The bench drives stimulus and emulated gate feedback on the falling edge. A behavioural model advances on the rising edge from the same sampled inputs. Outputs are compared with the model on the next falling edge, so every cycle is checked at the first point where its result is due.

// File: rtl/gnd_pkg.sv
package gnd_pkg;
    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_LS_ON   = 3'd1,
        ST_WAIT_HS = 3'd2,
        ST_HS_ON   = 3'd3,
        ST_WAIT_LS = 3'd4
    } gate_state_t;
endpackage

// File: rtl/gnd_duty_cmp.sv
module gnd_duty_cmp #(
    parameter int CNT_W = 10
) (
    input  logic [CNT_W-1:0] phase_cnt,
    input  logic [CNT_W-1:0] duty_cmd,
    output logic             pwm_req
);
    // Request high while the period count is below the commanded on-time.
    always_comb begin
        pwm_req = (duty_cmd > phase_cnt);
    end
endmodule

// File: rtl/gnd_wait_timer.sv
module gnd_wait_timer #(
    parameter int DT_MAX = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(DT_MAX + 1);
    localparam logic [TW-1:0] LAST = TW'(DT_MAX - 1);

    logic [TW-1:0] wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wait_cnt <= '0;
        else if (run && wait_cnt != LAST)
            wait_cnt <= wait_cnt + 1'b1;
        else if (!run)
            wait_cnt <= '0;
    end

    always_comb begin
        expired = run && (wait_cnt == LAST);
    end

    AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        run && (wait_cnt == LAST) |=> !run) else $error("wait exceeded bound"); // R5
endmodule

// File: rtl/gnd_fsm.sv
module gnd_fsm
    import gnd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pwm_req,
    input  logic hs_off,
    input  logic ls_off,
    input  logic expired,
    output logic waiting,
    output logic hs_gate,
    output logic ls_gate,
    output logic dt_warn
);
    gate_state_t state, state_nxt;
    logic        warn_set;

    // Next-state decision
    always_comb begin
        state_nxt = state;
        warn_set  = 1'b0;
        unique case (state)
            ST_OFF:     state_nxt = pwm_req ? ST_WAIT_HS : ST_WAIT_LS;
            ST_LS_ON:   if (pwm_req) state_nxt = ST_WAIT_HS;
            ST_WAIT_HS: begin
                if (ls_off) begin
                    state_nxt = ST_HS_ON;
                end else if (expired) begin
                    state_nxt = ST_HS_ON;
                    warn_set  = 1'b1;
                end
            end
            ST_HS_ON:   if (!pwm_req) state_nxt = ST_WAIT_LS;
            ST_WAIT_LS: begin
                if (hs_off) begin
                    state_nxt = ST_LS_ON;
                end else if (expired) begin
                    state_nxt = ST_LS_ON;
                    warn_set  = 1'b1;
                end
            end
            default:    state_nxt = ST_OFF;
        endcase
        if (!enable) begin
            state_nxt = ST_OFF;
            warn_set  = 1'b0;
        end
    end

    // State register and sticky warning
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            dt_warn <= 1'b0;
        end else begin
            state <= state_nxt;
            if (warn_set)
                dt_warn <= 1'b1;
        end
    end

    // Outputs decoded from state
    always_comb begin
        hs_gate = 1'b0;
        ls_gate = 1'b0;
        waiting = 1'b0;
        unique case (state)
            ST_HS_ON:   hs_gate = 1'b1;
            ST_LS_ON:   ls_gate = 1'b1;
            ST_WAIT_HS,
            ST_WAIT_LS: waiting = 1'b1;
            default:    ;
        endcase
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate)) else $error("both gates on"); // R9
    AST_HS_AFTER_LS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> ($past(ls_off) || dt_warn)) else $error("hs on without ls off"); // R3
    AST_LS_AFTER_HS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate) |-> ($past(hs_off) || dt_warn)) else $error("ls on without hs off"); // R4
    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!hs_gate && !ls_gate)) else $error("gate on while disabled"); // R7
    AST_WARN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        dt_warn |=> dt_warn) else $error("warning cleared"); // R6
endmodule

// File: rtl/gate_nonoverlap_ctrl.sv
module gate_nonoverlap_ctrl #(
    parameter int PERIOD = 667,
    parameter int DT_MAX = 16,
    localparam int CNT_W = $clog2(PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] phase_cnt,
    input  logic [CNT_W-1:0] duty_cmd,
    input  logic             hs_off,
    input  logic             ls_off,
    output logic             hs_gate,
    output logic             ls_gate,
    output logic             dt_warn
);
    logic pwm_req;
    logic waiting;
    logic expired;

    gnd_duty_cmp #(.CNT_W(CNT_W)) u_cmp (
        .phase_cnt (phase_cnt),
        .duty_cmd  (duty_cmd),
        .pwm_req   (pwm_req)
    );

    gnd_wait_timer #(.DT_MAX(DT_MAX)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (waiting),
        .expired (expired)
    );

    gnd_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .pwm_req (pwm_req),
        .hs_off  (hs_off),
        .ls_off  (ls_off),
        .expired (expired),
        .waiting (waiting),
        .hs_gate (hs_gate),
        .ls_gate (ls_gate),
        .dt_warn (dt_warn)
    );
endmodule

// File: tb/gate_nonoverlap_ctrl_test.sv
module gate_nonoverlap_ctrl_test;
    localparam int PERIOD = 667;
    localparam int DT_MAX = 16;
    localparam int CNT_W  = $clog2(PERIOD + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [CNT_W-1:0] phase_cnt = '0;
    logic [CNT_W-1:0] duty_cmd = '0;
    logic hs_off = 1'b1;
    logic ls_off = 1'b1;
    logic hs_gate, ls_gate, dt_warn;

    gate_nonoverlap_ctrl #(.PERIOD(PERIOD), .DT_MAX(DT_MAX)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .phase_cnt(phase_cnt),
        .duty_cmd(duty_cmd), .hs_off(hs_off), .ls_off(ls_off),
        .hs_gate(hs_gate), .ls_gate(ls_gate), .dt_warn(dt_warn)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    // Emulated gate feedback
    int  fb_dly = 2;
    bit  stuck_hs = 0;
    bit  stuck_ls = 0;
    int  hs_low = 1000;
    int  ls_low = 1000;

    // Behavioural model: which gate owns the stage, and how long a hand-over has waited
    int  m_owner = 0;      // 0 none, 1 low side, 2 high side
    int  m_pending = 0;    // 0 none, 1 low side, 2 high side waiting to start
    int  m_waited = 0;
    bit  m_warn = 0;

    // Per-period tallies for whole-period checks
    int  per_hs = 0;
    int  per_ls = 0;
    int  first_on = -1;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_owner = 0; m_pending = 0; m_waited = 0; m_warn = 0;
        end else if (!enable) begin
            m_owner = 0; m_pending = 0; m_waited = 0;
        end else begin
            bit req;
            req = (int'(duty_cmd) > int'(phase_cnt));
            if (m_pending != 0) begin
                bit seen;
                seen = (m_pending == 2) ? ls_off : hs_off;
                if (seen || m_waited == DT_MAX - 1) begin
                    if (!seen) m_warn = 1;
                    m_owner = m_pending; m_pending = 0; m_waited = 0;
                end else begin
                    m_waited++;
                end
            end else if (m_owner == 0) begin
                m_pending = req ? 2 : 1; m_waited = 0;
            end else if (m_owner == 1 && req) begin
                m_owner = 0; m_pending = 2; m_waited = 0;
            end else if (m_owner == 2 && !req) begin
                m_owner = 0; m_pending = 1; m_waited = 0;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Compare, then update feedback and phase count, on the falling edge
    always @(negedge clk) begin
        check(hs_gate == (m_owner == 2), "R2/R3/R4 hs_gate vs model", hs_gate, m_owner == 2);
        check(ls_gate == (m_owner == 1), "R2/R3/R4 ls_gate vs model", ls_gate, m_owner == 1);
        check(dt_warn == m_warn, "R5/R6 dt_warn vs model", dt_warn, m_warn);
        check(!(hs_gate && ls_gate), "R9 overlap", hs_gate && ls_gate, 0);
        per_hs += hs_gate;
        per_ls += ls_gate;
        hs_low = hs_gate ? 0 : (hs_low < 1000 ? hs_low + 1 : hs_low);
        ls_low = ls_gate ? 0 : (ls_low < 1000 ? ls_low + 1 : ls_low);
        hs_off = !stuck_hs && (hs_low >= fb_dly);
        ls_off = !stuck_ls && (ls_low >= fb_dly);
        phase_cnt <= (int'(phase_cnt) == PERIOD - 1) ? '0 : phase_cnt + 1'b1;
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Align to the start of a period and clear tallies
    task automatic period_start();
        while (int'(phase_cnt) != PERIOD - 1) @(negedge clk);
        @(negedge clk);
        per_hs = 0;
        per_ls = 0;
    endtask

    always @(negedge clk) begin
        if (cycles > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            summary();
        end
    end

    initial begin
        wait_cycles(3);
        check(!hs_gate && !ls_gate && !dt_warn, "R1 reset state", {hs_gate, ls_gate, dt_warn}, 0);
        rst_n = 1'b1;
        wait_cycles(2);
        check(!hs_gate && !ls_gate, "R1 idle after reset", {hs_gate, ls_gate}, 0);

        // R10: enable from off goes through a wait state first
        duty_cmd = '0;
        fb_dly = 2;
        enable = 1'b1;
        @(negedge clk);
        check(!ls_gate, "R10 no gate in first cycle", ls_gate, 0);
        @(negedge clk);
        check(ls_gate, "R10 ls on after wait", ls_gate, 1);

        // R8: 0 % duty keeps low side on for the period
        period_start();
        wait_cycles(PERIOD);
        check(per_ls == PERIOD, "R8 zero duty ls full period", per_ls, PERIOD);
        check(per_hs == 0, "R8 zero duty hs never on", per_hs, 0);

        // R8: 100 % duty keeps high side on
        duty_cmd = CNT_W'(PERIOD);
        wait_cycles(PERIOD);
        period_start();
        wait_cycles(PERIOD);
        check(per_hs == PERIOD, "R8 full duty hs full period", per_hs, PERIOD);
        check(per_ls == 0, "R8 full duty ls never on", per_ls, 0);

        // R2/R3/R4: mid duties with varying feedback delay
        duty_cmd = CNT_W'(PERIOD / 2);
        fb_dly = 3;
        period_start();
        wait_cycles(PERIOD);
        check(per_hs > 0 && per_ls > 0, "R2 half duty both gates used", per_hs, PERIOD / 2);
        check(per_hs + per_ls >= PERIOD - 2 * (DT_MAX + 2), "R3 dead time bounded", per_hs + per_ls, PERIOD);

        duty_cmd = CNT_W'(PERIOD / 4);
        fb_dly = 0;
        wait_cycles(2 * PERIOD);

        duty_cmd = 1;
        fb_dly = 5;
        wait_cycles(2 * PERIOD);
        check(!dt_warn, "R5 no warning with prompt feedback", dt_warn, 0);

        // R5: stuck high-side feedback forces the timeout path
        duty_cmd = CNT_W'(PERIOD / 2);
        stuck_hs = 1;
        wait_cycles(2 * PERIOD);
        check(dt_warn, "R5 warning after timeout", dt_warn, 1);
        stuck_hs = 0;
        stuck_ls = 1;
        wait_cycles(PERIOD);
        stuck_ls = 0;

        // R7: disable forces both off; R6 warning stays
        duty_cmd = CNT_W'(PERIOD);
        wait_cycles(PERIOD);
        enable = 1'b0;
        @(negedge clk);
        check(!hs_gate && !ls_gate, "R7 disabled gates off", {hs_gate, ls_gate}, 0);
        wait_cycles(50);
        check(!hs_gate && !ls_gate, "R7 stay off while disabled", {hs_gate, ls_gate}, 0);
        check(dt_warn, "R6 warning held through disable", dt_warn, 1);

        // R10: re-enable into full duty
        enable = 1'b1;
        @(negedge clk);
        check(!hs_gate, "R10 hs not on first cycle", hs_gate, 0);
        wait_cycles(DT_MAX + 2);
        check(hs_gate, "R10 hs on after wait", hs_gate, 1);
        wait_cycles(PERIOD);

        rst_n = 1'b0;
        @(negedge clk);
        check(!dt_warn && !hs_gate && !ls_gate, "R1 warning cleared by reset", dt_warn, 0);
        summary();
    end
endmodule